// File: doc/BRIEF.md
# Tag SECDED Scrub-and-Retry Controller

This block sits between a cache's tag lookup logic and its tag array and keeps every stored tag under a single-error-correct, double-error-detect code. On a tag write it appends check bits to the tag and writes the whole entry to the array. On a lookup it reads the entry back, decodes it and compares the tag against the lookup address. The array does not store the low address bits, which are always zero, so the comparison puts them back as zeros.

The block does more than report a faulty entry. When the decoder finds a single flipped bit, in either the tag or the check bits, it writes the corrected entry back to the array. It then reads the entry again, and only that second read produces the response. When the decoder finds two flipped bits, it writes the entry back as invalid and reports a miss that carries an error flag. If the read that follows a scrub still shows an error, the fault is taken to be persistent and the entry is invalidated in the same way. Two saturating counters record how many corrections and how many invalidations have taken place.

The tag array is outside the block. It has a one-cycle read latency and stores, next to each 38-bit entry, a valid bit that the block drives on every write.

Top module: `tag_scrub_ctrl`

## Requirements
- R1: A write accepted while `wr_ready` is high puts one entry into the array in that same cycle. The entry holds the tag in bits 30:0 and seven check bits in bits 37:31, so that an XOR over all 38 bits gives 0. The valid bit is written as 1.
- R2: A lookup accepted while `lk_ready` is high on an error-free valid entry answers in the next cycle. `rsp_hit` is 1 only when the stored tag shifted left by one, with a 0 as bit 0, equals `lk_addr`.
- R3: A lookup address whose bit 0 is 1 never hits, because the stored low bit is always zero.
- R4: A lookup on an entry whose valid bit is 0 answers in the next cycle as a miss, with `rsp_fixed` and `rsp_bad` both low, whatever the stored bits are.
- R5: A single flipped bit at any of the 38 positions is corrected. In the second cycle after acceptance the original entry is written back, in the third cycle the entry is read again, and in the fourth cycle the response arrives with `rsp_fixed` set and a hit decided on the corrected tag.
- R6: While a scrub or its retry is in progress, no response is given and `lk_ready` is low. The array is never read and written in the same cycle.
- R7: Two flipped bits cause the entry to be rewritten with valid 0 in the second cycle after acceptance. That same cycle carries a miss response with `rsp_bad` set.
- R8: If the retry read after a scrub still decodes with an error, the entry is invalidated and a miss with `rsp_bad` set is given in the fifth cycle after acceptance.
- R9: `cnt_corr` counts scrubs and `cnt_uncorr` counts invalidations caused by errors. Both hold at all ones instead of wrapping.
- R10: After reset the block is idle: both ready outputs are high, nothing accesses the array, no response is given and both counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Tag write request |
| wr_idx | input | 6 | Entry index for the write |
| wr_tag | input | 31 | Tag to store |
| wr_ready | output | 1 | Write accepted this cycle when high |
| lk_req | input | 1 | Lookup request |
| lk_idx | input | 6 | Entry index for the lookup |
| lk_addr | input | 32 | Address tag to compare, low bit included |
| lk_ready | output | 1 | Lookup accepted this cycle when high |
| rsp_valid | output | 1 | Lookup response present |
| rsp_hit | output | 1 | Entry valid, clean and matching |
| rsp_fixed | output | 1 | Response follows a scrub and retry |
| rsp_bad | output | 1 | Entry invalidated because of an uncorrectable error |
| ram_re | output | 1 | Array read strobe |
| ram_we | output | 1 | Array write strobe |
| ram_idx | output | 6 | Array entry index |
| ram_wdata | output | 38 | Entry written to the array |
| ram_wvalid | output | 1 | Valid bit written with the entry |
| ram_rdata | input | 38 | Entry read from the array, one cycle after `ram_re` |
| ram_rvalid | input | 1 | Valid bit read with the entry |
| cnt_corr | output | 8 | Saturating count of corrections |
| cnt_uncorr | output | 8 | Saturating count of invalidations |

## Verification
The bench sweeps a single upset across all 38 entry bits, one position per run, with a different tag each time. This separates a correct mapping of data and check positions from one that mends only the tag field, and shows whether the overall parity bit, which leaves a zero syndrome, is handled on its own. Double upsets are placed both across the tag and check fields and inside the tag field, to show that they invalidate instead of miscorrecting. A persistent upset, added back on every read, drives the retry path into invalidation. Clean lookups with matching, mismatching and odd addresses, together with lookups on never-written entries, separate the tag compare from the error handling. The response latency is checked in every cycle, and long runs of upsets push both counters into saturation.

// File: rtl/tag_scrub_ctrl.sv
module tag_scrub_ctrl #(
  parameter int TAG_W = 31,
  parameter int ZB    = 1,
  parameter int IDX_W = 6,
  parameter int CNT_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [TAG_W-1:0]      wr_tag,
  output logic                  wr_ready,
  input  logic                  lk_req,
  input  logic [IDX_W-1:0]      lk_idx,
  input  logic [TAG_W+ZB-1:0]   lk_addr,
  output logic                  lk_ready,
  output logic                  rsp_valid,
  output logic                  rsp_hit,
  output logic                  rsp_fixed,
  output logic                  rsp_bad,
  output logic                  ram_re,
  output logic                  ram_we,
  output logic [IDX_W-1:0]      ram_idx,
  output logic [TAG_W+7-1:0]    ram_wdata,
  output logic                  ram_wvalid,
  input  logic [TAG_W+7-1:0]    ram_rdata,
  input  logic                  ram_rvalid,
  output logic [CNT_W-1:0]      cnt_corr,
  output logic [CNT_W-1:0]      cnt_uncorr
);

  function automatic int ham_bits(input int n);
    int r = 1;
    while ((1 << r) < n + r + 1) r++;
    return r;
  endfunction

  localparam int HAM_W  = ham_bits(TAG_W);
  localparam int CHK_W  = HAM_W + 1;
  localparam int ENT_W  = TAG_W + CHK_W;
  localparam int NPOS   = TAG_W + HAM_W;
  localparam int ADDR_W = TAG_W + ZB;

  typedef logic [ENT_W-1:0] ent_t;
  typedef enum logic [2:0] {S_IDLE, S_READ, S_SCRUB, S_RETRY, S_INVAL} st_t;

  function automatic logic [HAM_W-1:0] f_syn(input ent_t w);
    logic [HAM_W-1:0] s = '0;
    int d = 0;
    int k = 0;
    for (int p = 1; p <= NPOS; p++) begin
      if ((p & (p - 1)) == 0) begin
        if (w[TAG_W + k]) s ^= HAM_W'(p);
        k++;
      end else begin
        if (w[d]) s ^= HAM_W'(p);
        d++;
      end
    end
    return s;
  endfunction

  function automatic ent_t f_enc(input logic [TAG_W-1:0] t);
    ent_t w = ent_t'(t);
    w[TAG_W +: HAM_W] = f_syn(w);
    w[ENT_W-1] = ^w[ENT_W-2:0];
    return w;
  endfunction

  function automatic ent_t f_fix(input ent_t w, input logic [HAM_W-1:0] s);
    ent_t o = w;
    int d = 0;
    int k = 0;
    if (s == '0) o[ENT_W-1] = ~w[ENT_W-1];
    for (int p = 1; p <= NPOS; p++) begin
      if ((p & (p - 1)) == 0) begin
        if (p == int'(s)) o[TAG_W + k] = ~w[TAG_W + k];
        k++;
      end else begin
        if (p == int'(s)) o[d] = ~w[d];
        d++;
      end
    end
    return o;
  endfunction

  st_t               st;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] addr_q;
  logic              retried;
  ent_t              fix_q;

  logic [HAM_W-1:0] syn;
  logic par, clean, single, inc_c, inc_u, in_read;

  assign syn     = f_syn(ram_rdata);
  assign par     = ^ram_rdata;
  assign clean   = (syn == '0) && !par;
  assign single  = par && (int'(syn) <= NPOS);
  assign in_read = (st == S_READ) && ram_rvalid;
  assign inc_c   = in_read && !clean && single && !retried;
  assign inc_u   = in_read && !clean && !(single && !retried);

  assign wr_ready   = (st == S_IDLE);
  assign lk_ready   = (st == S_IDLE) && !wr_en;
  assign rsp_valid  = ((st == S_READ) && (!ram_rvalid || clean)) || (st == S_INVAL);
  assign rsp_hit    = in_read && clean &&
                      ((ADDR_W'(ram_rdata[TAG_W-1:0]) << ZB) == addr_q);
  assign rsp_fixed  = (st == S_READ) && rsp_valid && retried;
  assign rsp_bad    = (st == S_INVAL);

  assign ram_re     = ((st == S_IDLE) && lk_req && !wr_en) || (st == S_RETRY);
  assign ram_we     = ((st == S_IDLE) && wr_en) || (st == S_SCRUB) || (st == S_INVAL);
  assign ram_wvalid = (st != S_INVAL);
  assign ram_idx    = (st != S_IDLE) ? idx_q : (wr_en ? wr_idx : lk_idx);
  assign ram_wdata  = (st == S_SCRUB) ? fix_q :
                      (st == S_INVAL) ? '0 : f_enc(wr_tag);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      idx_q      <= '0;
      addr_q     <= '0;
      retried    <= 1'b0;
      fix_q      <= '0;
      cnt_corr   <= '0;
      cnt_uncorr <= '0;
    end else begin
      if (inc_c && cnt_corr != '1)   cnt_corr   <= cnt_corr + 1'b1;
      if (inc_u && cnt_uncorr != '1) cnt_uncorr <= cnt_uncorr + 1'b1;
      case (st)
        S_IDLE: if (lk_req && !wr_en) begin
          st      <= S_READ;
          idx_q   <= lk_idx;
          addr_q  <= lk_addr;
          retried <= 1'b0;
        end
        S_READ: begin
          if (inc_c) begin
            st      <= S_SCRUB;
            fix_q   <= f_fix(ram_rdata, syn);
            retried <= 1'b1;
          end else if (inc_u) st <= S_INVAL;
          else                st <= S_IDLE;
        end
        S_SCRUB: st <= S_RETRY;
        S_RETRY: st <= S_READ;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_we && ram_re)); // R6
  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SCRUB || st == S_RETRY) |-> !rsp_valid && !lk_ready); // R6
  AST_SCRUB_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && st == S_SCRUB) |=> ram_re && !ram_we); // R5
  AST_FIXED_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fixed |-> $past(ram_re) && $past(ram_we, 2)); // R5
  AST_INVAL_WR: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_bad |-> ram_we && !ram_wvalid && !rsp_hit); // R7
  AST_NO_ODD_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> (addr_q & ADDR_W'((1 << ZB) - 1)) == '0); // R3
  AST_SAT_CORR: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_corr == '1 |=> cnt_corr == '1); // R9
  AST_SAT_UNCORR: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_uncorr == '1 |=> cnt_uncorr == '1); // R9

endmodule

// File: tb/tag_scrub_ctrl_bench.sv
module tag_scrub_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        wr_en = 0, lk_req = 0;
  logic [5:0]  wr_idx = 0, lk_idx = 0;
  logic [30:0] wr_tag = 0;
  logic [31:0] lk_addr = 0;
  logic wr_ready, lk_ready, rsp_valid, rsp_hit, rsp_fixed, rsp_bad;
  logic ram_re, ram_we, ram_wvalid, ram_rvalid;
  logic [5:0]  ram_idx;
  logic [37:0] ram_wdata, ram_rdata;
  logic [7:0]  cnt_corr, cnt_uncorr;

  tag_scrub_ctrl u_tag_scrub_ctrl (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_ready(wr_ready),
    .lk_req(lk_req), .lk_idx(lk_idx), .lk_addr(lk_addr), .lk_ready(lk_ready),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fixed(rsp_fixed), .rsp_bad(rsp_bad),
    .ram_re(ram_re), .ram_we(ram_we), .ram_idx(ram_idx), .ram_wdata(ram_wdata),
    .ram_wvalid(ram_wvalid), .ram_rdata(ram_rdata), .ram_rvalid(ram_rvalid),
    .cnt_corr(cnt_corr), .cnt_uncorr(cnt_uncorr)
  );

  logic [37:0] mem [64];
  logic        vld [64];
  logic [37:0] stuck [64] = '{default: '0};
  logic        inj_go = 0;
  logic [5:0]  inj_idx = 0;
  logic [37:0] inj_mask = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) begin mem[i] <= '0; vld[i] <= 1'b0; end
      ram_rdata <= '0; ram_rvalid <= 1'b0;
    end else begin
      if (ram_re) begin
        ram_rdata  <= mem[ram_idx] ^ stuck[ram_idx];
        ram_rvalid <= vld[ram_idx];
      end
      if (ram_we) begin mem[ram_idx] <= ram_wdata; vld[ram_idx] <= ram_wvalid; end
      if (inj_go) mem[inj_idx] <= mem[inj_idx] ^ inj_mask;
    end
  end

  int checks = 0, fails = 0;
  int exp_c = 0, exp_u = 0;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_write(input logic [5:0] idx, input logic [30:0] tag, output logic [37:0] word);
    @(negedge clk);
    wr_en = 1; wr_idx = idx; wr_tag = tag;
    chk("R1", "wr_ready", wr_ready, 1);
    @(negedge clk);
    wr_en = 0;
    word = mem[idx];
    chk("R1", "stored tag", word[30:0], tag);
    chk("R1", "stored valid", vld[idx], 1);
    chk("R1", "even overall parity", ^word, 0);
  endtask

  task automatic inject(input logic [5:0] idx, input logic [37:0] mask);
    @(negedge clk);
    inj_go = 1; inj_idx = idx; inj_mask = mask;
    @(negedge clk);
    inj_go = 0;
  endtask

  task automatic lookup(input string req, input logic [5:0] idx, input logic [31:0] addr,
                        input int lat, input logic eh, input logic ef, input logic eb,
                        input int ic, input int iu);
    @(negedge clk);
    lk_req = 1; lk_idx = idx; lk_addr = addr;
    chk(req, "lk_ready at request", lk_ready, 1);
    exp_c = (exp_c + ic > 255) ? 255 : exp_c + ic;
    exp_u = (exp_u + iu > 255) ? 255 : exp_u + iu;
    @(negedge clk);
    lk_req = 0;
    for (int c = 1; c <= lat + 1; c++) begin
      chk(req, "rsp_valid timing", rsp_valid, (c == lat));
      if (c < lat) chk("R6", "lk_ready held low", lk_ready, 0);
      if (c == lat) begin
        chk(req, "rsp_hit", rsp_hit, eh);
        chk(req, "rsp_fixed", rsp_fixed, ef);
        chk(req, "rsp_bad", rsp_bad, eb);
        chk("R9", "cnt_corr", cnt_corr, exp_c);
        chk("R9", "cnt_uncorr", cnt_uncorr, exp_u);
      end
      if (c == lat + 1) chk(req, "lk_ready after response", lk_ready, 1);
      if (c <= lat) @(negedge clk);
    end
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL R10 watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [37:0] w;
    logic [30:0] t;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk("R10", "wr_ready", wr_ready, 1);
    chk("R10", "lk_ready", lk_ready, 1);
    chk("R10", "rsp_valid", rsp_valid, 0);
    chk("R10", "ram access", {ram_re, ram_we}, 0);
    chk("R10", "cnt_corr", cnt_corr, 0);
    chk("R10", "cnt_uncorr", cnt_uncorr, 0);

    // R1 R2 R3: clean entry
    do_write(6'd3, 31'h2ABC_1357, w);
    lookup("R2", 6'd3, {31'h2ABC_1357, 1'b0}, 1, 1, 0, 0, 0, 0);
    lookup("R3", 6'd3, {31'h2ABC_1357, 1'b1}, 1, 0, 0, 0, 0, 0);
    lookup("R2", 6'd3, {31'h2ABC_1356, 1'b0}, 1, 0, 0, 0, 0, 0);
    do_write(6'd9, 31'h0, w);
    chk("R1", "zero tag check bits", w[37:31], 0);
    lookup("R2", 6'd9, 32'h0, 1, 1, 0, 0, 0, 0);

    // R4: never written entry with garbage bits
    inject(6'd5, 38'h3F_0000_0005);
    lookup("R4", 6'd5, {31'h0, 1'b0}, 1, 0, 0, 0, 0, 0);

    // R5: single upset at every bit position
    for (int b = 0; b < 38; b++) begin
      t = 31'(32'h5A5A_1234 + b * 7919);
      do_write(6'd2, t, w);
      inject(6'd2, 38'd1 << b);
      lookup("R5", 6'd2, {t, 1'b0}, 4, 1, 1, 0, 1, 0);
      chk("R5", "scrubbed entry", mem[2], w);
      chk("R5", "scrubbed valid", vld[2], 1);
    end
    // R5: corrected tag that mismatches the address
    do_write(6'd4, 31'h1111_2222, w);
    inject(6'd4, 38'd1 << 36);
    lookup("R5", 6'd4, {31'h1111_2223, 1'b0}, 4, 0, 1, 0, 1, 0);

    // R7: double upsets
    do_write(6'd7, 31'h7654_3210, w);
    inject(6'd7, (38'd1 << 0) | (38'd1 << 35));
    lookup("R7", 6'd7, {31'h7654_3210, 1'b0}, 2, 0, 0, 1, 0, 1);
    chk("R7", "invalidated", vld[7], 0);
    do_write(6'd8, 31'h0F0F_F0F0, w);
    inject(6'd8, (38'd1 << 5) | (38'd1 << 20));
    lookup("R7", 6'd8, {31'h0F0F_F0F0, 1'b0}, 2, 0, 0, 1, 0, 1);
    chk("R7", "invalidated", vld[8], 0);
    lookup("R4", 6'd8, {31'h0F0F_F0F0, 1'b0}, 1, 0, 0, 0, 0, 0);

    // R8: persistent upset defeats the retry
    stuck[6] = 38'd1 << 4;
    do_write(6'd6, 31'h3333_4444, w);
    lookup("R8", 6'd6, {31'h3333_4444, 1'b0}, 5, 0, 0, 1, 1, 1);
    chk("R8", "invalidated", vld[6], 0);
    stuck[6] = '0;

    // R9: saturation of both counters
    for (int i = 0; i < 220; i++) begin
      do_write(6'd10, 31'(i * 3 + 1), w);
      inject(6'd10, 38'd1 << (i % 38));
      lookup("R9", 6'd10, {31'(i * 3 + 1), 1'b0}, 4, 1, 1, 0, 1, 0);
    end
    for (int i = 0; i < 256; i++) begin
      do_write(6'd11, 31'(i * 5 + 2), w);
      inject(6'd11, 38'd3 << (i % 30));
      lookup("R9", 6'd11, {31'(i * 5 + 2), 1'b0}, 2, 0, 0, 1, 0, 1);
    end
    chk("R9", "cnt_corr saturated", cnt_corr, 8'hFF);
    chk("R9", "cnt_uncorr saturated", cnt_uncorr, 8'hFF);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule